// File: doc/BRIEF.md
# Parallel Flash Byte Programming Controller

This block fronts a small on-chip code memory and serves its parallel programming port. An external programmer presents an address, a data byte and a three-bit operation code, then raises a program strobe. A byte program is self-timed. A full-array erase needs the strobe held for a qualifying interval. Lock-bit programming is immediate. While an operation runs, the `busy` output stays high. A verify read of the byte being written returns its bitwise inverse until the write lands, which lets the programmer poll for completion through the data lines.

The memory is modelled as a register array inside the block. The high-voltage program enable is a plain digital input. The `HV_PART` parameter selects the variant: it decides whether that enable is needed and which identity byte is reported. There is no back-pressure. Each rising edge of the strobe is one command, and a command that cannot run is dropped and flagged on `err`. The programmer paces itself with `busy` and polling. Read data is combinational from the address and operation code, and it is valid for as long as they are held. The signature addresses are 6-bit values, so `AW` must be at least 6.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset every array byte reads FFh in verify mode (code 000), `busy` is 0 and `err` is 0, and both lock bits are clear.
- R2: A strobe rising edge with code 001 aimed at a byte that reads FFh starts a write: `busy` is 1 from the next cycle for exactly WR_CYC cycles, and then verify reads of that address return the written byte.
- R3: A code 001 strobe aimed at a byte that is not FFh leaves the array unchanged and gives a single-cycle `err` pulse in the cycle after the edge.
- R4: A strobe rising edge with code 001, 010, 011 or 100 that arrives while `busy` is 1 is dropped, and it gives a single-cycle `err` pulse.
- R5: While a write is in progress, a verify read of its address returns the bitwise inverse of the data being written. Verify reads of other addresses return the stored contents.
- R6: Code 010 with the strobe held high for ER_CYC cycles after its rising edge sets every byte to FFh and clears both lock bits. `busy` is 1 throughout the hold.
- R7: If the strobe falls or the code leaves 010 before the erase completes, `busy` drops on the next clock and the array and lock bits are unchanged.
- R8: Codes 011 and 100 set lock bits A and B. The bits are sticky and only a completed erase clears them. While either bit is set, verify reads of stored bytes return 00h, and no mode reads a lock bit out.
- R9: In code 101, address 30h reads 1Eh, 31h reads 51h, and 32h reads FFh when HV_PART=1 or 05h when HV_PART=0. All other addresses read 00h.
- R10: With HV_PART=1, a program, erase or lock strobe that arrives while `hv_en` is 0 is dropped and gives an `err` pulse.
- R11: Strobes with codes 000, 101, 110 or 111 start nothing and raise no `err`. Codes 110 and 111 read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_en | input | 1 | Digital stand-in for the high-voltage program enable |
| mode | input | 3 | Operation code: 000 verify, 001 byte program, 010 erase, 011 lock A, 100 lock B, 101 signature, 110/111 unused |
| addr | input | AW | Byte address |
| wdata | input | 8 | Byte to program |
| strobe | input | 1 | Program strobe; a rising edge issues a command, and erase needs it held |
| rdata | output | 8 | Read data for verify, polling and signature |
| busy | output | 1 | High while a write or erase is running |
| err | output | 1 | One-cycle pulse when a command is dropped |

## Verification
A wrong count in the busy timer shows on `busy` within one cycle of the expected release. The same fault also shows on the first verify read of the written address, which keeps returning the inverted byte. A corrupted poll latch or array word is visible on the very next verify read of that address. A lock bit that is lost or set wrongly shows as 00h or as real data on the next verify read of any stored byte. Because the reference model is compared on every clock, any such divergence is reported in the cycle it first reaches a port.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  typedef enum logic [2:0] {
    MD_VERIFY = 3'd0,
    MD_BYTE   = 3'd1,
    MD_ERASE  = 3'd2,
    MD_LOCK_A = 3'd3,
    MD_LOCK_B = 3'd4,
    MD_SIG    = 3'd5,
    MD_RSV6   = 3'd6,
    MD_RSV7   = 3'd7
  } pmode_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_ERASE = 2'd2,
    ACT_LOCK  = 2'd3
  } act_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam logic [7:0] SIG_MAKER  = 8'h1E;
  localparam logic [7:0] SIG_PART   = 8'h51;
  localparam logic [7:0] SIG_HV     = 8'hFF;
  localparam logic [7:0] SIG_LV     = 8'h05;
endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
  import nvm_prog_pkg::*;
#(
  parameter bit HV_PART = 1'b1
) (
  input  logic       strobe_rise,
  input  pmode_e     md,
  input  logic       busy,
  input  logic       hv_en,
  input  logic [7:0] target_byte,
  output act_e       act,
  output logic [1:0] lock_set,
  output logic       reject
);
  logic is_pgm_op;
  logic hv_block;

  assign is_pgm_op = (md == MD_BYTE) || (md == MD_ERASE) ||
                     (md == MD_LOCK_A) || (md == MD_LOCK_B);
  assign hv_block  = HV_PART && !hv_en;

  always_comb begin
    act      = ACT_NONE;
    lock_set = 2'b00;
    reject   = 1'b0;
    if (strobe_rise && is_pgm_op) begin
      if (busy || hv_block) begin
        reject = 1'b1;
      end else begin
        case (md)
          MD_BYTE: begin
            if (target_byte != BLANK_BYTE) reject = 1'b1;
            else                           act    = ACT_WRITE;
          end
          MD_ERASE:  act = ACT_ERASE;
          MD_LOCK_A: begin act = ACT_LOCK; lock_set = 2'b01; end
          MD_LOCK_B: begin act = ACT_LOCK; lock_set = 2'b10; end
          default:   act = ACT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int WR_CYC = 5,
  parameter int ER_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_er,
  input  logic hold_er,
  output logic busy,
  output logic erasing,
  output logic wr_done,
  output logic er_done
);
  localparam int MAXC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last    = (cnt == '0);
  assign wr_done = busy && !erasing && last;
  assign er_done = busy && erasing && hold_er && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      erasing <= 1'b0;
      cnt     <= '0;
    end else if (start_wr) begin
      busy    <= 1'b1;
      erasing <= 1'b0;
      cnt     <= CW'(WR_CYC - 1);
    end else if (start_er) begin
      busy    <= 1'b1;
      erasing <= 1'b1;
      cnt     <= CW'(ER_CYC - 1);
    end else if (busy) begin
      if ((erasing && !hold_er) || last) begin
        busy    <= 1'b0;
        erasing <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
  import nvm_prog_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          clr,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_read_mux.sv
module nvm_read_mux
  import nvm_prog_pkg::*;
#(
  parameter int AW      = 6,
  parameter bit HV_PART = 1'b1
) (
  input  pmode_e        md,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic          erasing,
  input  logic [AW-1:0] poll_addr,
  input  logic [7:0]    poll_data,
  input  logic          lock_any,
  input  logic [7:0]    cell_byte,
  output logic [7:0]    rdata
);
  localparam logic [AW-1:0] SIG_A0 = AW'(8'h30);
  localparam logic [AW-1:0] SIG_A1 = AW'(8'h31);
  localparam logic [AW-1:0] SIG_A2 = AW'(8'h32);
  localparam logic [7:0]    SIG_V2 = HV_PART ? SIG_HV : SIG_LV;

  logic polling;
  assign polling = busy && !erasing && (addr == poll_addr);

  always_comb begin
    rdata = 8'h00;
    case (md)
      MD_VERIFY: begin
        if (polling)       rdata = ~poll_data;
        else if (!lock_any) rdata = cell_byte;
      end
      MD_SIG: begin
        if (addr == SIG_A0)      rdata = SIG_MAKER;
        else if (addr == SIG_A1) rdata = SIG_PART;
        else if (addr == SIG_A2) rdata = SIG_V2;
      end
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_prog_pkg::*;
#(
  parameter int AW      = 6,
  parameter int WR_CYC  = 5,
  parameter int ER_CYC  = 20,
  parameter bit HV_PART = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_en,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          strobe,
  output logic [7:0]    rdata,
  output logic          busy,
  output logic          err
);
  pmode_e        md;
  logic          strobe_q;
  logic          strobe_rise;
  act_e          act;
  logic [1:0]    lock_set;
  logic          reject;
  logic [1:0]    lock_q;
  logic [AW-1:0] wr_addr_q;
  logic [7:0]    wr_data_q;
  logic          erasing;
  logic          wr_done;
  logic          er_done;
  logic [7:0]    cell_byte;
  logic          hold_er;

  assign md          = pmode_e'(mode);
  assign strobe_rise = strobe && !strobe_q;
  assign hold_er     = strobe && (md == MD_ERASE);

  nvm_cmd_decode #(.HV_PART(HV_PART)) u_dec (
    .strobe_rise (strobe_rise),
    .md          (md),
    .busy        (busy),
    .hv_en       (hv_en),
    .target_byte (cell_byte),
    .act         (act),
    .lock_set    (lock_set),
    .reject      (reject)
  );

  nvm_op_timer #(.WR_CYC(WR_CYC), .ER_CYC(ER_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (act == ACT_WRITE),
    .start_er (act == ACT_ERASE),
    .hold_er  (hold_er),
    .busy     (busy),
    .erasing  (erasing),
    .wr_done  (wr_done),
    .er_done  (er_done)
  );

  nvm_cell_array #(.AW(AW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_done),
    .waddr (wr_addr_q),
    .wdata (wr_data_q),
    .clr   (er_done),
    .raddr (addr),
    .rdata (cell_byte)
  );

  nvm_read_mux #(.AW(AW), .HV_PART(HV_PART)) u_rd (
    .md        (md),
    .addr      (addr),
    .busy      (busy),
    .erasing   (erasing),
    .poll_addr (wr_addr_q),
    .poll_data (wr_data_q),
    .lock_any  (|lock_q),
    .cell_byte (cell_byte),
    .rdata     (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      err       <= 1'b0;
      lock_q    <= 2'b00;
      wr_addr_q <= '0;
      wr_data_q <= 8'h00;
    end else begin
      strobe_q <= strobe;
      err      <= reject;
      if (act == ACT_WRITE) begin
        wr_addr_q <= addr;
        wr_data_q <= wdata;
      end
      if (er_done) lock_q <= 2'b00;
      else         lock_q <= lock_q | lock_set;
    end
  end
endmodule

// File: rtl/nvm_prog_chk.sv
module nvm_prog_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe,
  input logic          strobe_rise,
  input logic [2:0]    mode,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata,
  input logic          busy,
  input logic          erasing,
  input logic          err,
  input logic [1:0]    lock_q,
  input logic          er_done,
  input logic [AW-1:0] wr_addr_q,
  input logic [7:0]    wr_data_q
);
  p_busy_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(strobe_rise));

  p_err_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && busy && mode == 3'd1) |=> err);

  p_poll_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erasing && mode == 3'd0 && addr == wr_addr_q) |-> (rdata == ~wr_data_q));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && !strobe) |=> !busy);

  p_lock_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[0] && !er_done) |=> lock_q[0]);

  p_lock_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[1] && !er_done) |=> lock_q[1]);

  p_sig_maker_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && addr == AW'(8'h30)) |-> (rdata == 8'h1E));
endmodule

bind nvm_prog_ctrl nvm_prog_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe      (strobe),
  .strobe_rise (strobe_rise),
  .mode        (mode),
  .addr        (addr),
  .rdata       (rdata),
  .busy        (busy),
  .erasing     (erasing),
  .err         (err),
  .lock_q      (lock_q),
  .er_done     (er_done),
  .wr_addr_q   (wr_addr_q),
  .wr_data_q   (wr_data_q)
);

// File: tb/sim_nvm_prog_ctrl.sv
module sim_nvm_prog_ctrl;
  localparam int AW  = 6;
  localparam int WRC = 5;
  localparam int ERC = 20;
  localparam bit HVP = 1'b1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hv_en = 1'b1;
  logic          strobe = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  wire  [7:0]    rdata;
  wire           busy;
  wire           err;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  nvm_prog_ctrl #(.AW(AW), .WR_CYC(WRC), .ER_CYC(ERC), .HV_PART(HVP)) u0 (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .mode(mode), .addr(addr),
    .wdata(wdata), .strobe(strobe), .rdata(rdata), .busy(busy), .err(err)
  );

  // Behavioural reference: remaining busy cycles, stored bytes, lock flags.
  logic [7:0] m_mem [64];
  int         m_left;
  bit         m_er;
  bit [1:0]   m_lk;
  logic [5:0] m_wa;
  logic [7:0] m_wd;
  bit         m_err;
  bit         m_sq;
  bit         pb, rise, rej;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_left = 0; m_er = 0; m_lk = 0; m_wa = 0; m_wd = 0; m_err = 0; m_sq = 0;
    end else begin
      pb = (m_left > 0);
      if (pb) begin
        if (m_er && !(strobe && mode == 3'd2)) m_left = 0;
        else begin
          m_left--;
          if (m_left == 0) begin
            if (m_er) begin
              foreach (m_mem[i]) m_mem[i] = 8'hFF;
              m_lk = 0;
            end else m_mem[m_wa] = m_wd;
          end
        end
      end
      rise = strobe && !m_sq;
      rej  = 0;
      if (rise && mode >= 3'd1 && mode <= 3'd4) begin
        if (pb || (HVP && !hv_en)) rej = 1;
        else if (mode == 3'd1) begin
          if (m_mem[addr] !== 8'hFF) rej = 1;
          else begin m_left = WRC; m_er = 0; m_wa = addr; m_wd = wdata; end
        end
        else if (mode == 3'd2) begin m_left = ERC; m_er = 1; end
        else if (mode == 3'd3) m_lk[0] = 1;
        else m_lk[1] = 1;
      end
      m_err = rej;
      m_sq  = strobe;
    end
  end

  function automatic logic [7:0] exp_rd();
    if (mode == 3'd0) begin
      if (m_left > 0 && !m_er && addr == m_wa) return ~m_wd;
      if (m_lk == 0) return m_mem[addr];
      return 8'h00;
    end
    if (mode == 3'd5) begin
      if (addr == 6'h30) return 8'h1E;
      if (addr == 6'h31) return 8'h51;
      if (addr == 6'h32) return HVP ? 8'hFF : 8'h05;
      return 8'h00;
    end
    return 8'h00;
  endfunction

  function automatic string rd_tag();
    if (mode == 3'd5) return "R9";
    if (mode == 3'd0 && m_left > 0 && !m_er && addr == m_wa) return "R5";
    if (mode == 3'd0 && m_lk != 0) return "R8";
    if (mode >= 3'd6) return "R11";
    return "R2";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !fin) begin
      chk("R2 busy vs model", {7'd0, busy}, {7'd0, (m_left > 0)});
      chk("R3 err vs model", {7'd0, err}, {7'd0, m_err});
      chk(rd_tag(), rdata, exp_rd());
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  initial begin
    #(200_000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    mode = 3'd0; addr = 6'd5; #1;
    chk("R1 blank after reset", rdata, 8'hFF);
    chk("R1 busy idle", {7'd0, busy}, 8'd0);
    chk("R1 err idle", {7'd0, err}, 8'd0);

    mode = 3'd1; addr = 6'd3; wdata = 8'hA5; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0; #1;
    chk("R2 busy after strobe", {7'd0, busy}, 8'd1);
    chk("R5 poll returns inverse", rdata, 8'h5A);
    addr = 6'd4; #1;
    chk("R5 other address", rdata, 8'hFF);
    step();
    mode = 3'd1; addr = 6'd10; wdata = 8'h11; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0; addr = 6'd3; #1;
    chk("R4 strobe while busy", {7'd0, err}, 8'd1);
    step(WRC);
    #1;
    chk("R2 busy released", {7'd0, busy}, 8'd0);
    chk("R2 written data", rdata, 8'hA5);
    addr = 6'd10; #1;
    chk("R4 dropped write left blank", rdata, 8'hFF);

    mode = 3'd1; addr = 6'd3; wdata = 8'h00; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0; #1;
    chk("R3 non-blank flagged", {7'd0, err}, 8'd1);
    chk("R3 no busy", {7'd0, busy}, 8'd0);
    step(); #1;
    chk("R3 single pulse", {7'd0, err}, 8'd0);
    chk("R3 contents kept", rdata, 8'hA5);

    mode = 3'd6; strobe = 1'b1;
    step();
    strobe = 1'b0; #1;
    chk("R11 unused code no err", {7'd0, err}, 8'd0);
    chk("R11 unused code no busy", {7'd0, busy}, 8'd0);
    chk("R11 unused code reads zero", rdata, 8'h00);
    step();

    hv_en = 1'b0; mode = 3'd1; addr = 6'd7; wdata = 8'h3C; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0; #1;
    chk("R10 no enable flagged", {7'd0, err}, 8'd1);
    chk("R10 no enable no busy", {7'd0, busy}, 8'd0);
    step(); hv_en = 1'b1; #1;
    chk("R10 byte untouched", rdata, 8'hFF);

    mode = 3'd5;
    addr = 6'h30; #1; chk("R9 maker id", rdata, 8'h1E);
    addr = 6'h31; #1; chk("R9 part id", rdata, 8'h51);
    addr = 6'h32; #1; chk("R9 variant id", rdata, 8'hFF);
    addr = 6'h33; #1; chk("R9 other address", rdata, 8'h00);
    step();

    mode = 3'd2; strobe = 1'b1;
    step(3); #1;
    chk("R7 busy while held", {7'd0, busy}, 8'd1);
    strobe = 1'b0;
    step(); #1;
    chk("R7 abort releases busy", {7'd0, busy}, 8'd0);
    mode = 3'd0; addr = 6'd3; #1;
    chk("R7 array unchanged", rdata, 8'hA5);
    step();

    mode = 3'd3; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0; addr = 6'd3; #1;
    chk("R8 locked read hidden", rdata, 8'h00);
    step(4); #1;
    chk("R8 lock sticky", rdata, 8'h00);
    mode = 3'd4; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0; #1;
    chk("R8 second lock no err", {7'd0, err}, 8'd0);
    step();

    mode = 3'd2; strobe = 1'b1;
    step(5); #1;
    chk("R6 busy during erase", {7'd0, busy}, 8'd1);
    step(ERC - 3); #1;
    chk("R6 erase finished", {7'd0, busy}, 8'd0);
    strobe = 1'b0; mode = 3'd0; addr = 6'd3; #1;
    chk("R6 array erased", rdata, 8'hFF);
    chk("R8 erase clears locks", rdata, 8'hFF);
    step();

    mode = 3'd1; addr = 6'd3; wdata = 8'h3C; strobe = 1'b1;
    step();
    strobe = 1'b0; mode = 3'd0;
    step(WRC + 1); #1;
    chk("R2 reprogram after erase", rdata, 8'h3C);

    step(2);
    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule